// File: doc/BRIEF.md
# Two-Scan Debug Register Access Controller

This block sits on the data-register path of a JTAG test access port. It gives a debug host read and write access to a small internal bank of 32-bit debug registers. It follows the TAP's capture, shift and update strobes and samples TDI, all on the test clock. It drives TDO from its own shift register. The TAP state machine and the instruction decoder are outside the block. The decoder raises `path_sel` while the debug-access instruction is active, and that instruction uses the 10-bit code 0b0001111100.

Every register access takes exactly two data-register scans. The first scan is 8 bits long and carries a command byte. Bits 7..1 of the byte hold a register index and bit 0 holds the direction: 1 means write and 0 means read. The second scan is 32 bits long and moves the register contents. On a read, the addressed value is captured and shifted out. On a write, the value shifted in is committed when the update strobe arrives. Both scans shift least-significant bit first. Once the data scan completes, the controller waits for a command scan again. A test-logic reset also returns it to the command phase.

The bank holds `NUM_REGS` registers. Register i resets to the value formed by repeating its index byte four times and then XOR-ing the result with 0xC0DE0000. An index that has no register reads as zero, and writes to such an index are discarded.

Top module: `dbg_scan_access`

## Requirements
- R1: A command scan shifts 8 bits LSB first on `tdi`. At `update_dr`, the controller latches them as the command byte: index = bits 7..1, direction = bit 0 (1 = write, 0 = read).
- R2: The command byte is 0x00 after `rst_n` and after `tlr`. A `capture_dr` in the command phase loads the current command byte, which then appears on `tdo` LSB first.
- R3: The phases alternate. A command-phase `update_dr` moves the controller to the data phase, and a data-phase `update_dr` moves it back to the command phase.
- R4: In a data scan that follows a read command, `capture_dr` loads the addressed register, which is then shifted out on `tdo` over 32 bits, LSB first.
- R5: In a data scan that follows a write command, `capture_dr` loads zero. At `update_dr`, the 32 bits shifted in (first bit = bit 0) are written to the addressed register.
- R6: An index of `NUM_REGS` or above reads as zero. A write to such an index changes no register.
- R7: `tlr` forces the command phase and clears the command byte, whatever scan was in progress.
- R8: While `path_sel` is low, `capture_dr`, `shift_dr` and `update_dr` have no effect and `tdo` is 0.
- R9: After `rst_n`, register i holds {i[7:0], i[7:0], i[7:0], i[7:0]} XOR 0xC0DE0000. `tlr` does not alter the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| path_sel | input | 1 | Debug-access instruction is active |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |

## Verification
The bench runs read and write accesses to several mapped indices, using the data patterns all-ones, alternating nibbles and mixed words. This separates a correct LSB-first 32-bit transfer from a reversed, truncated or shifted one. Reads of never-written registers check the reset values. Writes and reads at index 100 show whether an out-of-range write leaks into a mapped register. A test-logic reset in the middle of an access, and a full scan with the path deselected, show whether phase and command state survive, reset or stay untouched as required.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
  localparam int CMD_W = 8;
  localparam int IDX_W = 7;

  typedef enum logic {PH_CMD = 1'b0, PH_DATA = 1'b1} phase_t;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             wr;
  } cmd_t;

  // Reset contents of bank register i: index byte repeated, then scrambled.
  function automatic logic [31:0] bank_rst_val(input int unsigned i);
    logic [7:0] b;
    b = i[7:0];
    return {b, b, b, b} ^ 32'hC0DE_0000;
  endfunction

  // One Shift-DR step, LSB out first; a short scan enters at the command MSB.
  function automatic logic [31:0] shift_step(input logic [31:0] cur, input logic din,
                                             input logic short_scan);
    logic [31:0] nxt;
    nxt = cur >> 1;
    if (short_scan) begin
      nxt[CMD_W-1] = din;
      nxt[31:CMD_W] = '0;
    end else begin
      nxt[31] = din;
    end
    return nxt;
  endfunction
endpackage

// File: rtl/dbg_scan_shifter.sv
module dbg_scan_shifter
  import dbg_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic [31:0] cap_val,
  input  logic        shift_en,
  input  logic        short_scan,
  input  logic        sdi,
  output logic [31:0] sr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (cap_en)   sr_q <= cap_val;
    else if (shift_en) sr_q <= shift_step(sr_q, sdi, short_scan);
  end
endmodule

// File: rtl/dbg_scan_ctrl.sv
module dbg_scan_ctrl
  import dbg_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tlr,
  input  logic             upd_en,
  input  logic [CMD_W-1:0] sr_low,
  output phase_t           phase,
  output cmd_t             cmd,
  output logic             cmd_commit,
  output logic             data_commit
);
  assign cmd_commit  = upd_en && !tlr && (phase == PH_CMD);
  assign data_commit = upd_en && !tlr && (phase == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD;
      cmd   <= '0;
    end else if (tlr) begin
      phase <= PH_CMD;
      cmd   <= '0;
    end else if (cmd_commit) begin
      cmd   <= cmd_t'(sr_low);
      phase <= PH_DATA;
    end else if (data_commit) begin
      phase <= PH_CMD;
    end
  end
endmodule

// File: rtl/dbg_scan_bank.sv
module dbg_scan_bank
  import dbg_scan_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data
);
  logic [31:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                regs[g] <= bank_rst_val(g);
      else if (wr_en && (wr_idx == IDX_W'(g)))   regs[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == IDX_W'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/dbg_scan_access.sv
module dbg_scan_access
  import dbg_scan_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tlr,
  input  logic path_sel,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic tdi,
  output logic tdo
);
  // Named internal events, also observed by the bound checker.
  logic        sel_cap, sel_shift, sel_upd;
  logic        cmd_commit, data_commit;
  logic        in_data, idx_mapped, rd_capture;
  logic [31:0] sr, rd_data, cap_val;
  phase_t      phase;
  cmd_t        cmd;

  assign sel_cap    = path_sel && capture_dr;
  assign sel_shift  = path_sel && shift_dr;
  assign sel_upd    = path_sel && update_dr;
  assign in_data    = (phase == PH_DATA);
  assign idx_mapped = ({25'b0, cmd.idx} < NUM_REGS);
  assign rd_capture = sel_cap && in_data && !cmd.wr;

  always_comb begin
    if (!in_data)    cap_val = {{(32-CMD_W){1'b0}}, cmd};
    else if (cmd.wr) cap_val = '0;
    else             cap_val = rd_data;
  end

  dbg_scan_shifter u_shift (
    .clk(tck), .rst_n(rst_n), .cap_en(sel_cap), .cap_val(cap_val),
    .shift_en(sel_shift), .short_scan(!in_data), .sdi(tdi), .sr_q(sr)
  );

  dbg_scan_ctrl u_ctrl (
    .clk(tck), .rst_n(rst_n), .tlr(tlr), .upd_en(sel_upd), .sr_low(sr[CMD_W-1:0]),
    .phase(phase), .cmd(cmd), .cmd_commit(cmd_commit), .data_commit(data_commit)
  );

  dbg_scan_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(tck), .rst_n(rst_n), .rd_idx(cmd.idx), .rd_data(rd_data),
    .wr_en(data_commit && cmd.wr), .wr_idx(cmd.idx), .wr_data(sr)
  );

  assign tdo = path_sel && sr[0];
endmodule

// File: rtl/dbg_scan_access_chk.sv
module dbg_scan_access_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tlr,
  input logic        path_sel,
  input logic        tdo,
  input logic        in_data,
  input logic [7:0]  cmd_byte,
  input logic        cmd_commit,
  input logic        data_commit,
  input logic        sel_cap,
  input logic        rd_capture,
  input logic        idx_mapped,
  input logic        cmd_wr,
  input logic [31:0] rd_data,
  input logic [31:0] sr
);
  p_cmd_to_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_commit |=> in_data);
  p_data_to_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_commit |=> !in_data);
  p_tlr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tlr |=> (!in_data && cmd_byte == 8'h00));
  p_idle_tdo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !path_sel |-> !tdo);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!path_sel && !tlr) |=> ($stable(cmd_byte) && $stable(in_data) && $stable(sr)));
  p_rd_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> sr == $past(rd_data));
  p_wr_capture_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cap && in_data && cmd_wr) |=> sr == 32'h0);
  p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_capture && !idx_mapped) |=> sr == 32'h0);
endmodule

bind dbg_scan_access dbg_scan_access_chk u_chk (
  .clk(tck), .rst_n(rst_n), .tlr(tlr), .path_sel(path_sel), .tdo(tdo),
  .in_data(in_data), .cmd_byte(cmd), .cmd_commit(cmd_commit),
  .data_commit(data_commit), .sel_cap(sel_cap), .rd_capture(rd_capture),
  .idx_mapped(idx_mapped), .cmd_wr(cmd.wr), .rd_data(rd_data), .sr(sr)
);

// File: tb/dbg_scan_access_tb_top.sv
`timescale 1ns/1ps
module dbg_scan_access_tb_top;
  localparam int NREG = 8;

  logic tck = 1'b0, rst_n = 1'b0, tlr = 1'b0, path_sel = 1'b1;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Reference model state
  logic [7:0] m_cmd;
  bit         m_data;
  logic [31:0] m_bank [128];

  always #2 tck = ~tck;

  dbg_scan_access #(.NUM_REGS(NREG)) dut_i (
    .tck(tck), .rst_n(rst_n), .tlr(tlr), .path_sel(path_sel),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo)
  );

  function automatic logic [31:0] exp_rst(input int i);
    return ((i & 255) * 32'h0101_0101) ^ 32'hC0DE_0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One full DR scan, starting and ending just after a falling edge.
  task automatic scan(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    capture_dr = 1'b1; @(negedge tck); capture_dr = 1'b0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1'b1; tdi = din[i];
      #1 dout[i] = tdo;
      @(negedge tck);
    end
    shift_dr = 1'b0; update_dr = 1'b1; @(negedge tck);
    update_dr = 1'b0; @(negedge tck);
  endtask

  task automatic cmd_pass(input int idx, input bit wr, input string req);
    logic [31:0] got;
    logic [7:0]  nb;
    nb = {idx[6:0], wr};
    scan(8, {24'b0, nb}, got);
    check(req, got, {24'b0, m_cmd});
    m_cmd = nb; m_data = 1'b1;
  endtask

  task automatic data_pass(input logic [31:0] wdata, input string req);
    logic [31:0] got, exp;
    int idx;
    idx = int'(m_cmd[7:1]);
    exp = m_cmd[0] ? 32'h0 : ((idx < NREG) ? m_bank[idx] : 32'h0);
    scan(32, wdata, got);
    check(req, got, exp);
    if (m_cmd[0] && idx < NREG) m_bank[idx] = wdata;
    m_data = 1'b0;
  endtask

  task automatic do_read(input int idx, input string req);
    cmd_pass(idx, 1'b0, "R1 command echo");
    data_pass(32'h0, req);
  endtask

  task automatic do_write(input int idx, input logic [31:0] v, input string req);
    cmd_pass(idx, 1'b1, "R1 command echo");
    data_pass(v, req);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] got;
    m_cmd = 8'h00; m_data = 1'b0;
    for (int i = 0; i < 128; i++) m_bank[i] = (i < NREG) ? exp_rst(i) : 32'h0;
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    @(negedge tck);
    check("R2 tdo after reset", {31'b0, tdo}, 32'h0);

    // R2 reset command echo, R4/R9 reset value reads
    do_read(3, "R4 R9 read reg3 reset value");
    do_read(0, "R9 read reg0 reset value");
    // R5 writes and read back, several patterns
    do_write(5, 32'h1234_5678, "R5 write capture zero");
    do_read(5, "R5 readback 12345678");
    do_read(4, "R4 neighbour reg4 untouched");
    do_write(0, 32'hFFFF_FFFF, "R5 write all ones");
    do_read(0, "R5 readback all ones");
    do_write(7, 32'hA5A5_5A5A, "R5 write reg7");
    do_read(7, "R4 readback reg7 pattern");
    // R6 unmapped index
    do_write(100, 32'hDEAD_BEEF, "R6 unmapped write capture");
    do_read(100, "R6 unmapped reads zero");
    for (int i = 0; i < NREG; i++) do_read(i, "R6 mapped regs unchanged");

    // R7: tlr mid-access returns to command phase with zero command
    cmd_pass(2, 1'b1, "R3 command before tlr");
    tlr = 1'b1; @(negedge tck); tlr = 1'b0; @(negedge tck);
    m_cmd = 8'h00; m_data = 1'b0;
    cmd_pass(2, 1'b0, "R7 R2 command echo zero after tlr");
    data_pass(32'h0, "R7 R9 reg2 read after tlr");

    // R8: deselected path ignores a full scan
    cmd_pass(6, 1'b0, "R3 command before deselect");
    path_sel = 1'b0;
    scan(32, 32'hFFFF_FFFF, got);
    check("R8 tdo zero while deselected", got, 32'h0);
    path_sel = 1'b1;
    data_pass(32'h0, "R8 R3 still in data phase, reg6");
    cmd_pass(1, 1'b0, "R8 R1 command byte preserved");
    data_pass(32'h0, "R3 phase returned after data pass");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule